// File: doc/BRIEF.md
# Synchronous Serial Port with Competing-Master Detection

This block moves 8-bit frames over a three-wire synchronous link made of a clock line, an outgoing data line and an incoming data line. An active-low select input qualifies each transfer. The most significant bit goes first. When set up as bus master, the block makes the link clock from the system clock. A prescaler divides the system clock by 1, 8 or 32, and a programmable divider then counts N+1 prescaled ticks per half bit. When set up as slave, it follows a clock applied from outside. Both the clock idle level and the clock phase can be selected.

A master on a shared bus has to step aside when another master takes the bus. If the select input is seen low while the block is master, the block treats it as a competing master. It aborts any frame in progress, releases its clock and data drivers, and sets a sticky fault flag that also drives the interrupt line. A clear request is obeyed in master mode only while select is high. In slave mode a clear request is always obeyed.

Software writes the control word, the divider value and the transmit byte through single-cycle strobes. It reads the received byte and acknowledges it with a read strobe, and it sees the status as plain output bits.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the port is idle. `busy`, `xfer_done`, `overrun`, `fault` and `irq` are 0, both output enables are 0, and `rx_rdata` is 0.
- R2: A `ctrl_wr` strobe loads `ctrl_wdata` with this layout: bit 0 selects master (1) or slave (0), bit 1 sets the clock idle level, bit 2 sets the clock phase, and bits 4:3 select the prescale ratio (0 gives 1, 1 gives 8, 2 and 3 give 32). In master mode with no fault, `sck_oe` is 1.
- R3: In master mode a `tx_wr` strobe accepted while idle starts a frame, and `busy` is 1 on the next cycle. Each half bit lasts (N+1) times the prescale ratio system cycles, where N is the value loaded by `div_wr`. `xfer_done` rises exactly 16 half bits after the accepting clock edge.
- R4: Data moves MSB first. With phase 0, the first bit is on `sdo_out` before the first clock edge, bits are sampled on leading edges and shifted on trailing edges. With phase 1, bits are shifted on leading edges and sampled on trailing edges.
- R5: A master frame makes exactly 16 transitions on `sck_out`. Whenever no frame is active, `sck_out` equals the selected idle level.
- R6: At the end of a frame the received byte appears on `rx_rdata` and `xfer_done` and `irq` are set. A `rx_rd` strobe clears `xfer_done`.
- R7: A `tx_wr` while `busy` is 1 does not change the frame in progress and sets `overrun`. The next `ctrl_wr` clears `overrun`.
- R8: In slave mode the port shifts on transitions of `sck_in` while `ss_n_in` is low. It drives `sdo_oe` only while selected and never drives `sck_oe`.
- R9: In master mode a low `ss_n_in` sets `fault` within 3 cycles, aborts the frame and drops both output enables. `fault` stays set after `ss_n_in` returns high, and `irq` is 1 while `fault` is 1. In slave mode `ss_n_in` never sets `fault`.
- R10: A `fault_clr` strobe is ignored in master mode while the synchronized select is low. It is obeyed in master mode while select is high, and in slave mode at any select level. Clearing the fault restores the output drivers.
- R11: A `tx_wr` while `fault` is 1 is ignored. No frame starts and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 5 | Control word: mode, idle level, phase, prescale select |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W (8) | Divider value N |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_wdata | input | 8 | Transmit byte |
| rx_rd | input | 1 | Received byte read strobe |
| rx_rdata | output | 8 | Last received byte |
| fault_clr | input | 1 | Fault clear request |
| xfer_done | output | 1 | Frame complete flag |
| overrun | output | 1 | Write-while-busy flag |
| fault | output | 1 | Competing-master fault flag |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Interrupt: done or fault |
| sck_in | input | 1 | Link clock from outside (slave mode) |
| sck_out | output | 1 | Link clock driven in master mode |
| sck_oe | output | 1 | Link clock driver enable |
| sdi_in | input | 1 | Incoming serial data |
| sdo_out | output | 1 | Outgoing serial data |
| sdo_oe | output | 1 | Outgoing data driver enable |
| ss_n_in | input | 1 | Active-low select |

## Verification
Each result has a fixed latency, and the bench samples it there. Flags written by strobes change at the edge that accepts the strobe. A master frame completes exactly 16·(N+1)·ratio cycles after the accepting edge, so the bench counts cycles from that edge and requires `xfer_done` to appear on exactly that count. `ss_n_in` and `sck_in` go through a two-stage synchronizer and act one edge after it, which puts a fault or a slave shift three cycles after the pin changes. The bench therefore waits four cycles before checking them, and it holds slave clock phases for six cycles. All outputs are read on the falling system clock edge, half a cycle after the registers update.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned FRAME_BITS   = 8;
  localparam int unsigned FRAME_EDGES  = 2 * FRAME_BITS;
  localparam int unsigned PRESCALE_MAX = 32;
  localparam int unsigned PRE_W        = $clog2(PRESCALE_MAX);

  // bit 0 master, bit 1 idle level, bit 2 phase, bits 4:3 prescale
  typedef struct packed {
    logic [1:0] psel;
    logic       cpha;
    logic       cpol;
    logic       master;
  } ssp_ctrl_t;

  function automatic int unsigned prescale_ratio(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 8;
      default: return PRESCALE_MAX;
    endcase
  endfunction
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssp_rate_gen.sv
module ssp_rate_gen
  import ssp_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       psel,
  input  logic [DIV_W-1:0] div_n,
  output logic             half_tick
);
  logic [PRE_W-1:0] pcnt;
  logic [DIV_W-1:0] dcnt;
  logic [PRE_W-1:0] pre_last;
  logic             src_tick;

  assign pre_last  = PRE_W'(prescale_ratio(psel) - 1);
  assign src_tick  = run && (pcnt == pre_last);
  assign half_tick = src_tick && (dcnt == div_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (!run) begin
      pcnt <= '0;
      dcnt <= '0;
    end else begin
      pcnt <= src_tick ? '0 : pcnt + 1'b1;
      if (src_tick) dcnt <= half_tick ? '0 : dcnt + 1'b1;
    end
  end

  AST_RATE_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (pcnt == '0 && dcnt == '0)); // R3
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
  import ssp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  edge_ev,
  input  logic                  cpha,
  input  logic                  sdi,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_data,
  input  logic                  arm,
  input  logic                  abort,
  output logic                  active,
  output logic                  frame_end,
  output logic                  tx_bit,
  output logic [FRAME_BITS-1:0] rx_word
);
  localparam int unsigned CW = $clog2(FRAME_EDGES);

  logic [CW-1:0]         k;
  logic [FRAME_BITS-1:0] tx_sr;
  logic [FRAME_BITS-1:0] rx_sr;
  logic [FRAME_BITS-1:0] rx_nx;
  logic                  is_sample;

  assign is_sample = (k[0] == cpha);
  assign rx_nx     = {rx_sr[FRAME_BITS-2:0], sdi};
  assign frame_end = edge_ev && !abort && (k == CW'(FRAME_EDGES - 1));
  assign tx_bit    = tx_sr[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k       <= '0;
      active  <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_word <= '0;
    end else begin
      if (abort) begin
        k      <= '0;
        active <= 1'b0;
      end else if (edge_ev) begin
        k      <= frame_end ? '0 : k + 1'b1;
        active <= !frame_end;
        if (is_sample) rx_sr <= rx_nx;
        if (frame_end) rx_word <= is_sample ? rx_nx : rx_sr;
      end else if (arm) begin
        active <= 1'b1;
      end
      if (load) tx_sr <= load_data;
      else if (edge_ev && !abort && !is_sample && k != '0)
        tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
    end
  end

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active); // R7
  AST_FRAME_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !active); // R6
endmodule

// File: rtl/ssp_fault.sv
module ssp_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic ss_low,
  input  logic clr_req,
  output logic set_ev,
  output logic fault
);
  logic clr_ok;

  assign set_ev = master && ss_low;
  assign clr_ok = clr_req && (!master || !ss_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fault <= 1'b0;
    else if (set_ev) fault <= 1'b1;
    else if (clr_ok) fault <= 1'b0;
  end

  AST_FAULT_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (master && ss_low) |=> fault); // R9
  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && master && ss_low) |=> fault); // R10
  AST_SLAVE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !master) |=> !fault); // R10
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_wr,
  input  logic [4:0]            ctrl_wdata,
  input  logic                  div_wr,
  input  logic [DIV_W-1:0]      div_wdata,
  input  logic                  tx_wr,
  input  logic [FRAME_BITS-1:0] tx_wdata,
  input  logic                  rx_rd,
  output logic [FRAME_BITS-1:0] rx_rdata,
  input  logic                  fault_clr,
  output logic                  xfer_done,
  output logic                  overrun,
  output logic                  fault,
  output logic                  busy,
  output logic                  irq,
  input  logic                  sck_in,
  output logic                  sck_out,
  output logic                  sck_oe,
  input  logic                  sdi_in,
  output logic                  sdo_out,
  output logic                  sdo_oe,
  input  logic                  ss_n_in
);
  ssp_ctrl_t        ctrl;
  logic [DIV_W-1:0] div_n;
  logic ss_n_s, sck_s, sck_prev, sck_lvl;
  logic half_tick, slave_sel, slave_edge, edge_ev;
  logic start_ok, arm, abort, active, frame_end, tx_bit;
  logic fault_set_ev, fault_q, done_f, ovr_f, run;

  ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
    .clk(clk), .rst_n(rst_n), .d(ss_n_in), .q(ss_n_s));
  ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_in), .q(sck_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      div_n <= '0;
    end else begin
      if (ctrl_wr) ctrl  <= ssp_ctrl_t'(ctrl_wdata);
      if (div_wr)  div_n <= div_wdata;
    end
  end

  // named internal events
  assign run        = ctrl.master && active && !fault_q;
  assign slave_sel  = !ctrl.master && !ss_n_s;
  assign slave_edge = slave_sel && (sck_s != sck_prev);
  assign edge_ev    = ctrl.master ? half_tick : slave_edge;
  assign start_ok   = tx_wr && !active && !fault_q;
  assign arm        = start_ok && ctrl.master;
  assign abort      = fault_set_ev || (!ctrl.master && ss_n_s);

  ssp_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .psel(ctrl.psel),
    .div_n(div_n), .half_tick(half_tick));

  ssp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .edge_ev(edge_ev), .cpha(ctrl.cpha),
    .sdi(sdi_in), .load(start_ok), .load_data(tx_wdata), .arm(arm),
    .abort(abort), .active(active), .frame_end(frame_end),
    .tx_bit(tx_bit), .rx_word(rx_rdata));

  ssp_fault u_fault (
    .clk(clk), .rst_n(rst_n), .master(ctrl.master), .ss_low(!ss_n_s),
    .clr_req(fault_clr), .set_ev(fault_set_ev), .fault(fault_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      sck_lvl  <= 1'b0;
      done_f   <= 1'b0;
      ovr_f    <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      if (abort || !ctrl.master) sck_lvl <= 1'b0;
      else if (half_tick)        sck_lvl <= ~sck_lvl;
      if (frame_end)  done_f <= 1'b1;
      else if (rx_rd) done_f <= 1'b0;
      if (tx_wr && active) ovr_f <= 1'b1;
      else if (ctrl_wr)    ovr_f <= 1'b0;
    end
  end

  assign sck_out   = ctrl.cpol ^ sck_lvl;
  assign sck_oe    = ctrl.master && !fault_q;
  assign sdo_out   = tx_bit;
  assign sdo_oe    = (ctrl.master || slave_sel) && !fault_q;
  assign xfer_done = done_f;
  assign overrun   = ovr_f;
  assign fault     = fault_q;
  assign busy      = active;
  assign irq       = done_f || fault_q;

  AST_FLOAT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (!sck_oe && !sdo_oe)); // R9
  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> xfer_done); // R6
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && active) |=> overrun); // R7
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sck_out == ctrl.cpol)); // R5
  AST_NO_START_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !active) |=> !active); // R11
endmodule

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_wr = 0, div_wr = 0, tx_wr = 0, rx_rd = 0, fault_clr = 0;
  logic [4:0] ctrl_wdata = '0;
  logic [7:0] div_wdata = '0, tx_wdata = '0, rx_rdata;
  logic       xfer_done, overrun, fault, busy, irq;
  logic       sck_in = 0, sck_out, sck_oe, sdi_in = 0, sdo_out, sdo_oe;
  logic       ss_n_in = 1;
  int         checks = 0, errors = 0;

  always #4 clk = ~clk;

  sync_serial_port dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .fault_clr(fault_clr),
    .xfer_done(xfer_done), .overrun(overrun), .fault(fault), .busy(busy),
    .irq(irq), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdi_in(sdi_in), .sdo_out(sdo_out), .sdo_oe(sdo_oe), .ss_n_in(ss_n_in));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] mk_ctrl(input logic m, input logic pol,
                                         input logic pha, input logic [1:0] ps);
    return {ps, pha, pol, m};
  endfunction

  function automatic int ratio_of(input logic [1:0] ps);
    if (ps == 2'd0) return 1;
    if (ps == 2'd1) return 8;
    return 32;
  endfunction

  task automatic put_ctrl(input logic [4:0] v);
    ctrl_wdata = v; ctrl_wr = 1; @(negedge clk); ctrl_wr = 0;
  endtask
  task automatic put_div(input logic [7:0] v);
    div_wdata = v; div_wr = 1; @(negedge clk); div_wr = 0;
  endtask
  task automatic put_tx(input logic [7:0] v);
    tx_wdata = v; tx_wr = 1; @(negedge clk); tx_wr = 0;
  endtask
  task automatic read_rx();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask
  task automatic clear_fault();
    fault_clr = 1; @(negedge clk); fault_clr = 0;
  endtask

  task automatic test_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "xfer_done", xfer_done, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "fault", fault, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "sck_oe", sck_oe, 0);
    chk("R1", "sdo_oe", sdo_oe, 0);
    chk("R1", "rx_rdata", rx_rdata, 0);
  endtask

  // bench acts as slave on the master's clock, polled at falling system edges
  task automatic test_master(input logic pol, input logic pha, input logic [1:0] ps,
                             input logic [7:0] n, input logic [7:0] txb,
                             input logic [7:0] pat);
    int h, done_at, edges, idx;
    logic prev, lead;
    logic [7:0] cap;
    put_ctrl(mk_ctrl(1'b1, pol, pha, ps));
    put_div(n);
    chk("R2", "sck_oe in master", sck_oe, 1);
    chk("R5", "sck idle level", sck_out, pol);
    h = (int'(n) + 1) * ratio_of(ps);
    idx = 0; sdi_in = pat[7]; prev = sck_out; edges = 0; cap = '0; done_at = -1;
    put_tx(txb);
    chk("R3", "busy after start", busy, 1);
    for (int i = 1; i <= 16 * h + 2; i++) begin
      @(negedge clk);
      if (sck_out !== prev) begin
        lead = (prev == pol);
        if (lead == !pha) cap = {cap[6:0], sdo_out};
        else if (pha) begin
          if (idx < 8) sdi_in = pat[3'(7 - idx)];
          idx++;
        end else begin
          idx++;
          if (idx < 8) sdi_in = pat[3'(7 - idx)];
        end
        edges++;
        prev = sck_out;
      end
      if (xfer_done && done_at < 0) done_at = i;
    end
    chk("R3", "cycles to done", done_at, 16 * h);
    chk("R3", "busy after frame", busy, 0);
    chk("R5", "clock transitions", edges, 16);
    chk("R5", "sck back to idle", sck_out, pol);
    chk("R4", "bits seen on sdo", cap, txb);
    chk("R6", "received byte", rx_rdata, pat);
    chk("R6", "irq on done", irq, 1);
    read_rx();
    chk("R6", "done cleared by read", xfer_done, 0);
    chk("R6", "irq cleared", irq, 0);
  endtask

  task automatic test_overrun();
    put_ctrl(mk_ctrl(1'b1, 1'b0, 1'b0, 2'd0));
    put_div(8'd1);
    tx_wdata = 8'hA5; tx_wr = 1; @(negedge clk); tx_wr = 0;
    sdi_in = sdo_out;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      sdi_in = sdo_out;
      if (i == 3) begin tx_wdata = 8'h3C; tx_wr = 1; end
      else tx_wr = 0;
      if (i == 4) chk("R7", "overrun set", overrun, 1);
    end
    chk("R7", "done after overrun", xfer_done, 1);
    chk("R7", "frame kept first byte", rx_rdata, 8'hA5);
    read_rx();
    put_ctrl(mk_ctrl(1'b1, 1'b0, 1'b0, 2'd0));
    chk("R7", "overrun cleared by ctrl write", overrun, 0);
  endtask

  task automatic test_slave(input logic pol, input logic pha,
                            input logic [7:0] txb, input logic [7:0] pat);
    int idx;
    logic [7:0] cap;
    sck_in = pol; ss_n_in = 1;
    put_ctrl(mk_ctrl(1'b0, pol, pha, 2'd0));
    repeat (4) @(negedge clk);
    chk("R8", "sdo_oe while deselected", sdo_oe, 0);
    chk("R8", "sck_oe in slave", sck_oe, 0);
    put_tx(txb);
    ss_n_in = 0; sdi_in = pat[7]; idx = 0; cap = '0;
    repeat (4) @(negedge clk);
    chk("R8", "sdo_oe while selected", sdo_oe, 1);
    chk("R9", "no fault in slave", fault, 0);
    for (int j = 0; j < 16; j++) begin
      repeat (6) @(negedge clk);
      if ((j % 2) == int'(pha)) cap = {cap[6:0], sdo_out};
      sck_in = ~sck_in;
      if ((j % 2) != int'(pha)) begin
        if (pha) begin
          if (idx < 8) sdi_in = pat[3'(7 - idx)];
          idx++;
        end else begin
          idx++;
          if (idx < 8) sdi_in = pat[3'(7 - idx)];
        end
      end
    end
    repeat (6) @(negedge clk);
    chk("R8", "slave done", xfer_done, 1);
    chk("R8", "slave received", rx_rdata, pat);
    chk("R8", "slave sent", cap, txb);
    read_rx();
    ss_n_in = 1;
    repeat (4) @(negedge clk);
    chk("R8", "sdo released", sdo_oe, 0);
  endtask

  task automatic test_fault();
    put_ctrl(mk_ctrl(1'b1, 1'b0, 1'b0, 2'd0));
    put_div(8'd3);
    put_tx(8'h55);
    repeat (5) @(negedge clk);
    chk("R9", "busy before fault", busy, 1);
    ss_n_in = 0;
    repeat (4) @(negedge clk);
    chk("R9", "fault set", fault, 1);
    chk("R9", "sck released", sck_oe, 0);
    chk("R9", "sdo released", sdo_oe, 0);
    chk("R9", "frame aborted", busy, 0);
    chk("R9", "irq on fault", irq, 1);
    clear_fault();
    @(negedge clk);
    chk("R10", "clear ignored while select low", fault, 1);
    put_tx(8'h11);
    chk("R11", "no start during fault", busy, 0);
    chk("R11", "no overrun during fault", overrun, 0);
    ss_n_in = 1;
    repeat (4) @(negedge clk);
    chk("R9", "fault sticky", fault, 1);
    clear_fault();
    chk("R10", "clear with select high", fault, 0);
    chk("R10", "sck driver restored", sck_oe, 1);
    ss_n_in = 0;
    repeat (4) @(negedge clk);
    chk("R9", "fault set again", fault, 1);
    put_ctrl(mk_ctrl(1'b0, 1'b0, 1'b0, 2'd0));
    clear_fault();
    chk("R10", "slave clear with select low", fault, 0);
    ss_n_in = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_master(1'b0, 1'b0, 2'd0, 8'd0, 8'hB2, 8'h4D);
    test_master(1'b1, 1'b1, 2'd1, 8'd2, 8'h81, 8'hC6);
    test_master(1'b0, 1'b1, 2'd0, 8'd3, 8'h5A, 8'h93);
    test_master(1'b1, 1'b0, 2'd2, 8'd1, 8'h0F, 8'hE1);
    test_overrun();
    test_slave(1'b0, 1'b0, 8'h96, 8'h3B);
    test_slave(1'b1, 1'b1, 8'h6C, 8'hA7);
    test_fault();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule